// File: doc/BRIEF.md
# I2C SCL Clock Divider Generator

This block produces the serial clock waveform for an I2C master from the bus clock it runs on. The division is done in two steps. A prescaler first divides the bus clock by a power of two, set by a 4-bit exponent. A phase counter then measures the high and low halves of each SCL period in prescaled units. The high and low lengths are programmed minus one, so a field of zero gives a phase of exactly one prescaled unit.

Each period starts with the high phase and ends after the low phase. A new set of field values is only taken in on the first bus clock of a period, so a change made mid-period never cuts a phase short. While the enable is low, SCL is released (high), every counter rests at zero, and the next enable starts a fresh period. Two single-cycle strobes mark the falling and rising edges of the generated clock. The master's shift and start/stop logic uses them.

A parameter selects 3-bit or 4-bit phase fields.

Top module: `scl_clkgen`

## Requirements
- R1: With exponent e, high field h and low field l, one SCL period lasts (2^e)·((h+1)+(l+1)) bus clock cycles: first (2^e)·(h+1) cycles with scl_o high, then (2^e)·(l+1) cycles with scl_o low.
- R2: A phase field value of 0 gives a phase of one prescaled unit, so h=0, l=0, e=0 toggles scl_o every bus clock cycle.
- R3: With WIDE_PHASE=1 the phase fields are 4 bits wide, and h=l=15 gives a combined period of 32 units. With WIDE_PHASE=0 they are 3 bits wide (maximum 8 units per phase, 16 combined).
- R4: An exponent of 0 means no prescaling. Any exponent from 0 to 15 scales both phases by 2^e, and 15 gives 32768 bus cycles per unit.
- R5: The exponent and phase fields are sampled only on the first bus clock cycle of a period. Changes during a period take effect from the next period onward.
- R6: While enable is low, scl_o is 1 and the period restarts. After enable goes high, the first period begins with a full high phase that uses the fields sampled on that first enabled cycle.
- R7: fall_pulse is 1 for exactly the first cycle in which scl_o is 0 after being 1. rise_pulse is 1 for exactly the first cycle in which scl_o is 1 after being 0, and this includes the release caused by dropping enable.
- R8: While rst_n is low, scl_o is 1 and both pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator; low releases SCL |
| div_exp | input | EXP_W (4) | Prescale exponent, divide by 2^div_exp |
| high_len | input | PH_W (3 or 4) | High phase length minus one, in prescaled units |
| low_len | input | PH_W (3 or 4) | Low phase length minus one, in prescaled units |
| scl_o | output | 1 | Generated SCL level |
| fall_pulse | output | 1 | One-cycle strobe on each falling edge of scl_o |
| rise_pulse | output | 1 | One-cycle strobe on each rising edge of scl_o |

## Verification
The fastest setting (all fields zero) tests whether the phase counter wraps on the correct count. A design that waits one extra tick would stretch every phase to two cycles. The all-ones phase fields and the largest exponent test the counter widths: a narrow prescaler or phase counter would wrap early and shorten the period. Fields are also rewritten in the middle of a period, which catches a design that adopts them at once and produces a runt phase. Enable is dropped while SCL is low to show that the release raises rise_pulse and that a later restart begins with a full high phase rather than resuming an old count.

// File: rtl/scl_clkgen_pkg.sv
package scl_clkgen_pkg;
  // phase field width for the narrow and wide variants
  function automatic int phase_width(input bit wide);
    return wide ? 4 : 3;
  endfunction

  // prescaler counter width needed for an exponent field of exp_w bits
  function automatic int prescale_width(input int exp_w);
    return (1 << exp_w) - 1;
  endfunction
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int EXP_W = 4,
  localparam int PRE_W = scl_clkgen_pkg::prescale_width(EXP_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q, cnt_d;
  logic [PRE_W:0]   one_hot, span;
  logic [PRE_W-1:0] limit;

  always_comb begin
    one_hot = (PRE_W+1)'(1) << exp_i;
    span    = one_hot - (PRE_W+1)'(1);
    limit   = span[PRE_W-1:0];
    tick    = run && (cnt_q == limit);
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/scl_phase.sv
module scl_phase #(
  parameter int PH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            tick,
  input  logic [PH_W-1:0] high_lim,
  input  logic [PH_W-1:0] low_lim,
  output logic            scl,
  output logic            fall,
  output logic            rise,
  output logic            period_end
);
  logic [PH_W-1:0] cnt_q, cnt_d, lim;
  logic            scl_q, scl_d, fall_q, rise_q, phase_end;

  always_comb begin
    lim        = scl_q ? high_lim : low_lim;
    phase_end  = tick && (cnt_q == lim);
    period_end = phase_end && !scl_q;
    if (!run)           cnt_d = '0;
    else if (phase_end) cnt_d = '0;
    else if (tick)      cnt_d = cnt_q + PH_W'(1);
    else                cnt_d = cnt_q;
    if (!run)           scl_d = 1'b1;
    else if (phase_end) scl_d = ~scl_q;
    else                scl_d = scl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      scl_q  <= 1'b1;
      fall_q <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      scl_q  <= scl_d;
      fall_q <= scl_q & ~scl_d;
      rise_q <= ~scl_q & scl_d;
    end
  end

  assign scl  = scl_q;
  assign fall = fall_q;
  assign rise = rise_q;
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
  parameter bit WIDE_PHASE = 1'b1,
  parameter int EXP_W      = 4,
  localparam int PH_W      = scl_clkgen_pkg::phase_width(WIDE_PHASE),
  localparam int CFG_W     = EXP_W + 2 * PH_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [EXP_W-1:0] div_exp,
  input  logic [PH_W-1:0]  high_len,
  input  logic [PH_W-1:0]  low_len,
  output logic             scl_o,
  output logic             fall_pulse,
  output logic             rise_pulse
);
  logic [CFG_W-1:0] cfg_q, cfg_d, cfg_in, cfg_eff;
  logic             start_q, start_d, cfg_load;
  logic             pre_tick, period_end;

  always_comb begin
    cfg_in   = {div_exp, high_len, low_len};
    cfg_eff  = start_q ? cfg_in : cfg_q;
    cfg_load = start_q & enable;
    cfg_d    = cfg_load ? cfg_in : cfg_q;
    start_d  = ~enable | period_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      start_q <= 1'b1;
    end else begin
      cfg_q   <= cfg_d;
      start_q <= start_d;
    end
  end

  scl_prescaler #(.EXP_W(EXP_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (enable),
    .exp_i (cfg_eff[CFG_W-1 -: EXP_W]),
    .tick  (pre_tick)
  );

  scl_phase #(.PH_W(PH_W)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (enable),
    .tick       (pre_tick),
    .high_lim   (cfg_eff[2*PH_W-1 -: PH_W]),
    .low_lim    (cfg_eff[PH_W-1:0]),
    .scl        (scl_o),
    .fall       (fall_pulse),
    .rise       (rise_pulse),
    .period_end (period_end)
  );
endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk #(
  parameter int CFG_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             scl_o,
  input logic             fall_pulse,
  input logic             rise_pulse,
  input logic             pre_tick,
  input logic             start_q,
  input logic [CFG_W-1:0] cfg_q
);
  // sampled fields stay frozen inside a period
  assert_cfg_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !start_q |=> $stable(cfg_q));

  // SCL moves only on a prescaled unit boundary while running
  assert_edge_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !pre_tick) |=> (scl_o == $past(scl_o)));

  // disabled generator releases the line
  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (scl_o && !fall_pulse));

  assert_fall_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_o) |-> fall_pulse);

  assert_rise_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_o) |-> rise_pulse);

  assert_pulse_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({fall_pulse, rise_pulse}) <= 1);
endmodule

bind scl_clkgen scl_clkgen_chk #(.CFG_W(CFG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .scl_o      (scl_o),
  .fall_pulse (fall_pulse),
  .rise_pulse (rise_pulse),
  .pre_tick   (pre_tick),
  .start_q    (start_q),
  .cfg_q      (cfg_q)
);

// File: tb/scl_clkgen_bench.sv
module scl_clkgen_bench;
  logic       clk;
  logic       rst_n;
  logic       enable;
  logic [3:0] div_exp;
  logic [3:0] high_len;
  logic [3:0] low_len;
  logic       scl_o, fall_pulse, rise_pulse;

  scl_clkgen u_scl_clkgen (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .div_exp    (div_exp),
    .high_len   (high_len),
    .low_len    (low_len),
    .scl_o      (scl_o),
    .fall_pulse (fall_pulse),
    .rise_pulse (rise_pulse)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  string cur_req = "R8";

  // behavioural reference: position within the period, fields per period
  bit m_scl = 1'b1, m_fall = 1'b0, m_rise = 1'b0, m_start = 1'b1, started = 1'b0;
  int m_pos = 0, m_e = 0, m_h = 0, m_l = 0;

  always @(posedge clk) begin
    int unit, hi_end, per_end;
    started = 1'b1;
    if (!rst_n) begin
      m_scl = 1'b1; m_fall = 1'b0; m_rise = 1'b0; m_pos = 0; m_start = 1'b1;
    end else if (!enable) begin
      m_fall = 1'b0; m_rise = !m_scl; m_scl = 1'b1; m_pos = 0; m_start = 1'b1;
    end else begin
      if (m_start) begin
        m_e = int'(div_exp); m_h = int'(high_len); m_l = int'(low_len);
        m_start = 1'b0;
      end
      unit    = 1 << m_e;
      hi_end  = unit * (m_h + 1);
      per_end = hi_end + unit * (m_l + 1);
      m_fall = 1'b0; m_rise = 1'b0;
      m_pos++;
      if (m_pos == hi_end) begin
        m_scl = 1'b0; m_fall = 1'b1;
      end else if (m_pos == per_end) begin
        m_scl = 1'b1; m_rise = 1'b1; m_pos = 0; m_start = 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      n_cmp++;
      if (scl_o !== m_scl || fall_pulse !== m_fall || rise_pulse !== m_rise) begin
        n_bad++;
        $display("FAIL %s at cycle %0d: scl/fall/rise actual %b%b%b expected %b%b%b",
                 cur_req, cyc, scl_o, fall_pulse, rise_pulse, m_scl, m_fall, m_rise);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected under 190000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input int e, input int h, input int l);
    div_exp = 4'(e); high_len = 4'(h); low_len = 4'(l);
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b0;
    set_cfg(0, 0, 0);
    cur_req = "R8";
    run(5);
    rst_n = 1'b1;
    run(3);
    // R2: fastest toggle
    cur_req = "R2"; enable = 1'b1;
    run(20);
    // R1: asymmetric phases, no prescale
    cur_req = "R1"; enable = 1'b0; set_cfg(0, 2, 5); run(2);
    enable = 1'b1; run(45);
    // R4: prescale by 4
    cur_req = "R4"; enable = 1'b0; set_cfg(2, 1, 3); run(2);
    enable = 1'b1; run(100);
    // R3: widest phase fields
    cur_req = "R3"; enable = 1'b0; set_cfg(0, 15, 15); run(2);
    enable = 1'b1; run(80);
    // R5: fields rewritten mid-period
    cur_req = "R5"; enable = 1'b0; set_cfg(1, 3, 3); run(2);
    enable = 1'b1; run(5);
    set_cfg(0, 0, 1); run(8);
    set_cfg(1, 2, 0); run(60);
    // R6 / R7: drop enable while SCL is low, then restart
    cur_req = "R6"; set_cfg(1, 1, 4);
    while (scl_o) run(1);
    run(2);
    cur_req = "R7"; enable = 1'b0; run(6);
    cur_req = "R6"; enable = 1'b1; run(40);
    // R4: largest exponent, one full period
    cur_req = "R4"; enable = 1'b0; set_cfg(15, 0, 0); run(2);
    enable = 1'b1; run(65600);
    enable = 1'b0; run(4);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule